// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces the fetch address for an eight-stage in-order pipeline (F1, F2, D1, D2, R1, R2, E, W). It tracks which fetched address has reached D2. There it acts on control-flow instructions that an outside decoder classifies: conditional branch, call, return, task end and debug stop. The taken/not-taken decision uses the flags and condition code present while the instruction sits in D2. The new fetch address shows up in the cycle the branch reaches E. The three instructions fetched behind a branch always run. The fetch then issues two empty slots while the branch passes R1 and R2.

A task is launched with a start vector. It runs until a task-end instruction reaches D2. A stall input freezes the sequencer. A single-step mode turns the debug stop into a halt, and after that the pipeline moves one cycle per step request. The block polices the shadow around control flow. A restricted instruction that lands too close to a branch, call or return sets a sticky error and is executed as a no-operation.

The state machine has three states. IDLE holds while no task runs. RUN fetches. DBG_HALT waits for step requests. Transitions are LAUNCH (IDLE to RUN on a start strobe), BREAK (RUN to DBG_HALT on a debug stop in D2 with stepping enabled), RESUME (DBG_HALT to RUN when stepping is disabled) and FINISH (RUN or DBG_HALT to IDLE on a task end in D2).

Top module: `pcseq_top`

## Requirements
- R1: After reset the block is idle: `busy`, `fetch_vld`, `halted`, `ret_we`, `task_done` and `slot_err` are all 0.
- R2: While idle, `start_vld` launches a task, and the next cycle shows `fetch_pc` = `start_pc` with `fetch_vld` = 1. Each advancing cycle then adds 1 to the fetch address. A `start_vld` while a task runs has no effect on the fetch sequence.
- R3: A taken control instruction (kind code 1 = jump, 2 = call, 3 = return) at address b reaches D2 while b+3 is being fetched. The next two advancing cycles have `fetch_vld` = 0. The third shows the destination with `fetch_vld` = 1. A not-taken one gives the same timing with destination b+4.
- R4: Condition codes on `d2_cond`: 0 always, 1 Z, 2 not Z, 3 N, 4 neither N nor Z, 5 N or Z, 6 not N, 7 T, 8 not T, 9..15 never. `flags` bit 0 is Z, bit 1 is N and bit 2 is T.
- R5: The decision uses `flags` only in the cycle the instruction is acted on in D2. Later flag changes do not alter the path.
- R6: A taken call pulses `ret_we` for one cycle, in the cycle after it is acted on in D2, with `ret_pc` = b+4. A not-taken call writes nothing.
- R7: A taken return redirects to `ret_field` as sampled in D2 and ignores `d2_target`.
- R8: Task end (kind code 4) in D2 ends the task. The next cycle shows `task_done` = 1, `busy` = 0 and `fetch_vld` = 0. While idle, decoder inputs are ignored.
- R9: While `stall` is 1 the fetch address, the D2 address and all sequencing freeze. The fetch sequence is the same as without the stall.
- R10: With `step_en` = 1, a debug stop (kind code 5) in D2 halts the pipeline with that instruction held in D2 and `halted` = 1. Each `step_req` cycle advances exactly one step. Clearing `step_en` resumes. With `step_en` = 0 a debug stop acts as a no-operation.
- R11: Kind codes 1..5 are restricted. A restricted instruction violates the shadow rule when it reaches D2 within three instructions after a control instruction, and a control instruction violates it within three instructions after any restricted one. A violation sets `slot_err`, which stays set until the next launch, and the offending instruction acts as a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_vld | input | 1 | Start strobe for a task |
| start_pc | input | PC_W | Start vector |
| stall | input | 1 | Freeze request from memory conflicts |
| step_en | input | 1 | Single-step mode enable |
| step_req | input | 1 | Advance one cycle while halted |
| d2_kind | input | 3 | Class of the instruction in D2 |
| d2_cond | input | 4 | Condition code of the instruction in D2 |
| d2_target | input | PC_W | Jump/call destination of the instruction in D2 |
| flags | input | 3 | Current flags {T, N, Z} |
| ret_field | input | PC_W | Saved return address used by a return |
| fetch_pc | output | PC_W | F1 fetch address |
| fetch_vld | output | 1 | Fetch address is real (not a bubble) |
| dec_pc | output | PC_W | Address of the instruction in D2 |
| dec_vld | output | 1 | D2 holds a real instruction |
| ret_we | output | 1 | Return-address capture strobe |
| ret_pc | output | PC_W | Captured return address |
| task_done | output | 1 | One-cycle task end indication |
| busy | output | 1 | A task is running or halted |
| halted | output | 1 | Debug halt active |
| slot_err | output | 1 | Sticky shadow violation flag |

## Verification
The hardest situation to reach from the ports is a control instruction that is itself the offender, because it sits just after a restricted instruction that behaved harmlessly. The stimulus puts a debug stop two slots before a jump while stepping is off. The debug stop passes as a no-operation, and the jump must then produce an unbroken sequential fetch trace with no bubbles. A second hard case is a debug halt: the bench has to land a step request in the exact held cycle, then read the fetch and D2 addresses one step later.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        K_PLAIN = 3'd0,
        K_JUMP  = 3'd1,
        K_CALL  = 3'd2,
        K_RET   = 3'd3,
        K_END   = 3'd4,
        K_BRK   = 3'd5
    } kind_e;

    typedef enum logic [3:0] {
        C_ALWAYS = 4'd0,
        C_ZERO   = 4'd1,
        C_NZERO  = 4'd2,
        C_NEG    = 4'd3,
        C_POS    = 4'd4,
        C_NPOS   = 4'd5,
        C_NNEG   = 4'd6,
        C_TSET   = 4'd7,
        C_TCLR   = 4'd8
    } cond_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RUN      = 2'd1,
        S_DBG_HALT = 2'd2
    } seq_state_e;

    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_T = 2;

    function automatic logic is_ctl(input logic [2:0] k);
        return (k == K_JUMP) || (k == K_CALL) || (k == K_RET);
    endfunction

    function automatic logic is_restricted(input logic [2:0] k);
        return (k >= K_JUMP) && (k <= K_BRK);
    endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [2:0] flags,
    output logic       taken
);
    logic z, n, t;
    assign z = flags[FLG_Z];
    assign n = flags[FLG_N];
    assign t = flags[FLG_T];

    always_comb begin
        case (cond)
            C_ALWAYS: taken = 1'b1;
            C_ZERO:   taken = z;
            C_NZERO:  taken = !z;
            C_NEG:    taken = n;
            C_POS:    taken = !n && !z;
            C_NPOS:   taken = n || z;
            C_NNEG:   taken = !n;
            C_TSET:   taken = t;
            C_TCLR:   taken = !t;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcseq_pipe.sv
module pcseq_pipe #(
    parameter int PC_W  = 16,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift,
    input  logic            clear,
    input  logic            in_vld,
    input  logic [PC_W-1:0] in_pc,
    output logic            out_vld,
    output logic [PC_W-1:0] out_pc
);
    logic [DEPTH-1:0] vld_q;
    logic [PC_W-1:0]  pc_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) pc_q[i] <= '0;
        end else if (clear) begin
            vld_q <= '0;
        end else if (shift) begin
            vld_q[0] <= in_vld;
            pc_q[0]  <= in_pc;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1];
                pc_q[i]  <= pc_q[i-1];
            end
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_pc  = pc_q[DEPTH-1];
endmodule

// File: rtl/pcseq_guard.sv
module pcseq_guard
    import pcseq_pkg::*;
#(
    parameter int SHADOW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       accept,
    input  logic       vld,
    input  logic [2:0] kind,
    output logic       viol,
    output logic       err
);
    localparam int GW = $clog2(SHADOW + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(SHADOW);

    logic [GW-1:0] gap_q;
    logic          prev_ctl_q;
    logic          restr, ctl;

    assign restr = is_restricted(kind);
    assign ctl   = is_ctl(kind);
    assign viol  = vld && restr && (gap_q < GAP_MAX) && (prev_ctl_q || ctl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q      <= GAP_MAX;
            prev_ctl_q <= 1'b0;
            err        <= 1'b0;
        end else if (init) begin
            gap_q      <= GAP_MAX;
            prev_ctl_q <= 1'b0;
            err        <= 1'b0;
        end else if (accept) begin
            if (viol) err <= 1'b1;
            if (restr && !viol) begin
                gap_q      <= '0;
                prev_ctl_q <= ctl;
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int DEC_DEPTH = 3,
    parameter int E_LAG     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_vld,
    input  logic [PC_W-1:0] start_pc,
    input  logic            stall,
    input  logic            step_en,
    input  logic            step_req,
    input  logic [2:0]      d2_kind,
    input  logic [3:0]      d2_cond,
    input  logic [PC_W-1:0] d2_target,
    input  logic [2:0]      flags,
    input  logic [PC_W-1:0] ret_field,
    output logic [PC_W-1:0] fetch_pc,
    output logic            fetch_vld,
    output logic [PC_W-1:0] dec_pc,
    output logic            dec_vld,
    output logic            ret_we,
    output logic [PC_W-1:0] ret_pc,
    output logic            task_done,
    output logic            busy,
    output logic            halted,
    output logic            slot_err
);
    localparam int HOLD_W = (E_LAG > 2) ? $clog2(E_LAG) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(E_LAG - 1);
    localparam logic [PC_W-1:0]   FALL_OFS  = PC_W'(DEC_DEPTH + 1);

    seq_state_e        st_q, st_d;
    logic [PC_W-1:0]   fpc_q;
    logic [HOLD_W-1:0] hold_q;
    logic              viol, taken;
    logic              launch, brk_now, adv, acc;
    logic [2:0]        act;
    logic              ctl_acc, end_acc;
    logic [PC_W-1:0]   dest;

    pcseq_cond u_cond (
        .cond  (d2_cond),
        .flags (flags),
        .taken (taken)
    );

    pcseq_pipe #(.PC_W(PC_W), .DEPTH(DEC_DEPTH)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (adv),
        .clear   (launch || end_acc),
        .in_vld  (fetch_vld),
        .in_pc   (fpc_q),
        .out_vld (dec_vld),
        .out_pc  (dec_pc)
    );

    pcseq_guard #(.SHADOW(DEC_DEPTH)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (launch),
        .accept (acc),
        .vld    (dec_vld),
        .kind   (d2_kind),
        .viol   (viol),
        .err    (slot_err)
    );

    // control decisions for the instruction in D2
    always_comb begin
        launch  = (st_q == S_IDLE) && start_vld;
        brk_now = (st_q == S_RUN) && !stall && dec_vld && (d2_kind == K_BRK)
                  && step_en && !viol;
        adv     = !stall && (((st_q == S_RUN) && !brk_now) ||
                             ((st_q == S_DBG_HALT) && step_req));
        acc     = adv && dec_vld;
        act     = viol ? K_PLAIN : d2_kind;
        ctl_acc = acc && is_ctl(act);
        end_acc = acc && (act == K_END);
        if (!taken)            dest = dec_pc + FALL_OFS;
        else if (act == K_RET) dest = ret_field;
        else                   dest = d2_target;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:     if (launch) st_d = S_RUN;              // LAUNCH
            S_RUN: begin
                if (end_acc)      st_d = S_IDLE;               // FINISH
                else if (brk_now) st_d = S_DBG_HALT;           // BREAK
            end
            S_DBG_HALT: begin
                if (end_acc)       st_d = S_IDLE;              // FINISH
                else if (!step_en) st_d = S_RUN;               // RESUME
            end
            default:    st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // outputs and fetch address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fpc_q     <= '0;
            hold_q    <= '0;
            ret_we    <= 1'b0;
            ret_pc    <= '0;
            task_done <= 1'b0;
        end else begin
            ret_we    <= ctl_acc && (act == K_CALL) && taken;
            task_done <= end_acc;
            if (ctl_acc && (act == K_CALL)) ret_pc <= dec_pc + FALL_OFS;
            if (launch) begin
                fpc_q  <= start_pc;
                hold_q <= '0;
            end else if (end_acc) begin
                hold_q <= '0;
            end else if (adv) begin
                if (ctl_acc) begin
                    fpc_q  <= dest;
                    hold_q <= HOLD_LOAD;
                end else begin
                    if (fetch_vld)      fpc_q  <= fpc_q + 1'b1;
                    if (hold_q != '0)   hold_q <= hold_q - 1'b1;
                end
            end
        end
    end

    assign fetch_pc  = fpc_q;
    assign fetch_vld = (st_q != S_IDLE) && (hold_q == '0);
    assign busy      = (st_q != S_IDLE);
    assign halted    = (st_q == S_DBG_HALT);
endmodule

// File: rtl/pcseq_checks.sv
module pcseq_checks #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic            step_req,
    input logic            start_vld,
    input logic            busy,
    input logic            halted,
    input logic [PC_W-1:0] fetch_pc,
    input logic            fetch_vld,
    input logic [PC_W-1:0] dec_pc,
    input logic            ret_we,
    input logic            task_done,
    input logic            slot_err
);
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && busy) |=> ($stable(fetch_pc) && $stable(dec_pc)));          // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !step_req) |=> $stable(fetch_pc));                         // R10
    AST_RET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_we |=> !ret_we);                                                  // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        task_done |-> (!busy && !fetch_vld));                                 // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fetch_vld && !halted));                                   // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_err && !(start_vld && !busy)) |=> slot_err);                    // R11
endmodule

bind pcseq_top pcseq_checks #(.PC_W(PC_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .step_req  (step_req),
    .start_vld (start_vld),
    .busy      (busy),
    .halted    (halted),
    .fetch_pc  (fetch_pc),
    .fetch_vld (fetch_vld),
    .dec_pc    (dec_pc),
    .ret_we    (ret_we),
    .task_done (task_done),
    .slot_err  (slot_err)
);

// File: tb/pcseq_top_tb_top.sv
`timescale 1ns/1ps
module pcseq_top_tb_top;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_vld, stall, step_en, step_req;
    logic [PW-1:0] start_pc, ret_field;
    logic [2:0]    flags;
    logic [2:0]    d2_kind;
    logic [3:0]    d2_cond;
    logic [PW-1:0] d2_target;
    logic [PW-1:0] fetch_pc, dec_pc, ret_pc;
    logic          fetch_vld, dec_vld, ret_we, task_done, busy, halted, slot_err;

    always #2.5 clk = ~clk;

    // instruction memory model feeding the D2 decode inputs
    logic [2:0]    pk [64];
    logic [3:0]    pcnd [64];
    logic [PW-1:0] ptg [64];
    assign d2_kind   = pk[dec_pc[5:0]];
    assign d2_cond   = pcnd[dec_pc[5:0]];
    assign d2_target = ptg[dec_pc[5:0]];

    pcseq_top #(.PC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_pc(start_pc),
        .stall(stall), .step_en(step_en), .step_req(step_req),
        .d2_kind(d2_kind), .d2_cond(d2_cond), .d2_target(d2_target),
        .flags(flags), .ret_field(ret_field),
        .fetch_pc(fetch_pc), .fetch_vld(fetch_vld), .dec_pc(dec_pc), .dec_vld(dec_vld),
        .ret_we(ret_we), .ret_pc(ret_pc), .task_done(task_done), .busy(busy),
        .halted(halted), .slot_err(slot_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // scoreboard
    typedef struct { logic v; logic [PW-1:0] pc; } item_t;
    item_t  expq [$];
    logic   mon_on = 1'b0;
    string  cur_tag = "";
    int     kidx, ret_n, ret_k, ret_v;

    task automatic push_seq(input int first, input int last);
        for (int a = first; a <= last; a++) expq.push_back('{1'b1, PW'(a)});
    endtask
    task automatic push_bub(input int n);
        for (int i = 0; i < n; i++) expq.push_back('{1'b0, '0});
    endtask
    task automatic exp_taken(input int t);
        push_seq(0, 7); push_bub(2); push_seq(t, t + 7);
    endtask
    task automatic exp_fall();
        push_seq(0, 7); push_bub(2); push_seq(8, 13);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && ret_we) begin
                ret_n++; ret_k = kidx; ret_v = int'(ret_pc);
            end
            if (mon_on && busy && !stall && !(halted && !step_req)) begin
                if (expq.size() == 0) begin
                    chk(1'b0, cur_tag, "extra fetch", int'(fetch_pc), -1);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    chk(fetch_vld == it.v, cur_tag, "fetch_vld", int'(fetch_vld), int'(it.v));
                    if (it.v)
                        chk(fetch_pc == it.pc, cur_tag, "fetch_pc", int'(fetch_pc), int'(it.pc));
                end
                kidx++;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic prog_clear();
        for (int i = 0; i < 64; i++) begin pk[i] = 3'd0; pcnd[i] = 4'd0; ptg[i] = '0; end
    endtask

    // control instruction at 4, task end at 10 (fall path) and at target+4
    task automatic prog_std(input logic [2:0] kind, input logic [3:0] cond, input int tgt);
        prog_clear();
        pk[4] = kind; pcnd[4] = cond; ptg[4] = PW'(tgt);
        pk[10] = 3'd4;
        pk[tgt + 4] = 3'd4;
    endtask

    task automatic run(input string tag, input logic [2:0] flip, input bit stl, input bit restart);
        int guard;
        cur_tag = tag; kidx = 0; ret_n = 0; ret_k = -1; ret_v = -1;
        mon_on = 1'b1;
        start_pc = '0; start_vld = 1'b1;
        wait_cyc(1);
        start_vld = 1'b0;
        wait_cyc(8);
        flags = flags ^ flip;
        if (stl) begin stall = 1'b1; wait_cyc(3); stall = 1'b0; end
        if (restart) begin start_pc = PW'(50); start_vld = 1'b1; wait_cyc(1); start_vld = 1'b0; end
        guard = 0;
        while (busy && guard < 300) begin wait_cyc(1); guard++; end
        chk(task_done == 1'b1, tag, "R8 task_done pulse", int'(task_done), 1);
        chk(fetch_vld == 1'b0, tag, "R8 fetch_vld after end", int'(fetch_vld), 0);
        chk(expq.size() == 0, tag, "missing fetches", expq.size(), 0);
        expq.delete();
        mon_on = 1'b0;
        wait_cyc(1);
        chk(task_done == 1'b0, tag, "R8 task_done single", int'(task_done), 0);
    endtask

    task automatic cond_case(input string tag, input logic [3:0] cond,
                             input logic [2:0] f, input bit tk);
        prog_std(3'd1, cond, 20);
        flags = f;
        if (tk) exp_taken(20); else exp_fall();
        run(tag, 3'b000, 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_vld = 1'b0; start_pc = '0; stall = 1'b0;
        step_en = 1'b0; step_req = 1'b0; flags = 3'b000; ret_field = '0;
        prog_clear();
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        chk(busy == 0 && fetch_vld == 0, "R1", "busy/fetch_vld", int'({busy, fetch_vld}), 0);
        chk(halted == 0 && ret_we == 0, "R1", "halted/ret_we", int'({halted, ret_we}), 0);
        chk(task_done == 0 && slot_err == 0, "R1", "task_done/slot_err",
            int'({task_done, slot_err}), 0);

        // R2 R3 taken jump, with an ignored restart while running
        prog_std(3'd1, 4'd0, 20); exp_taken(20);
        run("R2_R3_jump_restart", 3'b000, 1'b0, 1'b1);
        chk(slot_err == 0, "R11", "legal run no error", int'(slot_err), 0);

        // R4 condition codes, flags {T,N,Z}
        cond_case("R4_eq_nz", 4'd1, 3'b000, 1'b0);
        cond_case("R4_eq_z",  4'd1, 3'b001, 1'b1);
        cond_case("R4_ne_z",  4'd2, 3'b001, 1'b0);
        cond_case("R4_lt_n",  4'd3, 3'b010, 1'b1);
        cond_case("R4_gt_z",  4'd4, 3'b001, 1'b0);
        cond_case("R4_gt_p",  4'd4, 3'b000, 1'b1);
        cond_case("R4_le_z",  4'd5, 3'b001, 1'b1);
        cond_case("R4_ge_n",  4'd6, 3'b010, 1'b0);
        cond_case("R4_tf_t",  4'd7, 3'b100, 1'b1);
        cond_case("R4_ntf_t", 4'd8, 3'b100, 1'b0);
        cond_case("R4_never", 4'd12, 3'b111, 1'b0);

        // R5 flags change after the D2 decision, plus R9 stall in the bubbles
        prog_std(3'd1, 4'd1, 20); flags = 3'b001; exp_taken(20);
        run("R5_R9_flip_taken", 3'b001, 1'b1, 1'b0);
        prog_std(3'd1, 4'd2, 20); flags = 3'b001; exp_fall();
        run("R5_flip_fall", 3'b001, 1'b0, 1'b0);

        // R6 call
        prog_std(3'd2, 4'd0, 20); flags = 3'b000; exp_taken(20);
        run("R6_call", 3'b000, 1'b0, 1'b0);
        chk(ret_n == 1, "R6", "ret_we pulses", ret_n, 1);
        chk(ret_k == 8, "R6", "ret_we cycle", ret_k, 8);
        chk(ret_v == 8, "R6", "ret_pc", ret_v, 8);
        prog_std(3'd2, 4'd1, 20); flags = 3'b000; exp_fall();
        run("R6_call_not_taken", 3'b000, 1'b0, 1'b0);
        chk(ret_n == 0, "R6", "no capture when not taken", ret_n, 0);

        // R7 return uses ret_field, not d2_target
        prog_std(3'd3, 4'd0, 20); pk[34] = 3'd4; ret_field = PW'(30); exp_taken(30);
        run("R7_return", 3'b000, 1'b0, 1'b0);

        // R8 inputs ignored while idle
        wait_cyc(4);
        chk(busy == 0 && fetch_vld == 0, "R8", "idle stays quiet", int'({busy, fetch_vld}), 0);

        // R11 control instruction in a slot after a jump
        prog_std(3'd1, 4'd0, 20); pk[6] = 3'd1; ptg[6] = PW'(40); exp_taken(20);
        run("R11_after", 3'b000, 1'b0, 1'b0);
        chk(slot_err == 1, "R11", "slot_err after-rule", int'(slot_err), 1);
        wait_cyc(3);
        chk(slot_err == 1, "R11", "slot_err sticky", int'(slot_err), 1);
        // R11 jump two slots after a debug stop: the jump is the offender
        prog_clear(); pk[2] = 3'd5; pk[4] = 3'd1; ptg[4] = PW'(20); pk[10] = 3'd4;
        step_en = 1'b0; push_seq(0, 13);
        run("R11_before", 3'b000, 1'b0, 1'b0);
        chk(slot_err == 1, "R11", "slot_err before-rule", int'(slot_err), 1);
        prog_std(3'd1, 4'd0, 20); exp_taken(20);
        run("R11_clear_on_start", 3'b000, 1'b0, 1'b0);
        chk(slot_err == 0, "R11", "cleared by launch", int'(slot_err), 0);

        // R10 single step: debug stop at 3, task end at 12
        prog_clear(); pk[3] = 3'd5; pk[12] = 3'd4;
        step_en = 1'b1; start_pc = '0; start_vld = 1'b1;
        wait_cyc(1);
        start_vld = 1'b0;
        wait_cyc(8);
        chk(halted == 1, "R10", "halted", int'(halted), 1);
        chk(fetch_pc == 6, "R10", "held fetch_pc", int'(fetch_pc), 6);
        chk(dec_pc == 3, "R10", "held dec_pc", int'(dec_pc), 3);
        step_req = 1'b1;
        wait_cyc(1);
        step_req = 1'b0;
        chk(fetch_pc == 7, "R10", "one step fetch_pc", int'(fetch_pc), 7);
        chk(dec_pc == 4, "R10", "one step dec_pc", int'(dec_pc), 4);
        wait_cyc(3);
        chk(fetch_pc == 7 && halted == 1, "R10", "no step no move", int'(fetch_pc), 7);
        step_en = 1'b0;
        for (int g = 0; g < 100 && busy; g++) wait_cyc(1);
        chk(busy == 0 && halted == 0, "R10", "resume to end", int'({busy, halted}), 0);
        // R10 debug stop as no-operation with stepping off
        push_seq(0, 15);
        run("R10_nop", 3'b000, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule